// File: doc/BRIEF.md
# Offset-Range Cascaded Binary Counter

This block is an 8-bit synchronous binary counter whose steady-state cycle runs over the values 9 through 69 and then returns to 9. It is assembled from two identical 4-bit counter slices. Each slice can load a value, count, or hold, and it produces a carry-out. The carry-out of the lower slice enables the upper slice. A comparator watches for the last value of the range. Together with an explicit initialise request, it drives one shared load line that places the start value into both slices on the same clock edge.

The counter is used wherever a repeating count over an offset window is needed, such as a slot index or a frame position whose first legal value is not zero. The asynchronous reset clears the register to zero. From zero the counter counts upward until it first reaches 69. It enters the 9..69 window only through the initialise request or through the wrap.

Top module: `range_ctr`

## Requirements
- R1: While the active-low reset is asserted, and after its release until the first counting edge, `count` is 0 and `at_end` is 0.
- R2: With `init`=0, `cnt_en`=1 and `count` not equal to 69, the next clock edge sets `count` to `count`+1 in plain binary.
- R3: With `init`=0 and `cnt_en`=0, `count` keeps its value across the clock edge, including when `count` is 69.
- R4: With `init`=0, `cnt_en`=1 and `count` equal to 69 (binary 0100_0101), the next edge sets `count` to 9 (binary 0000_1001).
- R5: With `init`=1, the next edge sets `count` to 9 whatever the values of `cnt_en` and `count`. The load takes priority over counting.
- R6: `at_end` is 1 exactly in the cycles where `count` equals 69.
- R7: When the low nibble (bits 3..0) is 1111 and it counts, the high nibble (bits 7..4) advances by one on the same edge as the low nibble returns to 0000. For example, 15 is followed by 16 and 47 by 48.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the count to 0 |
| init | input | 1 | Synchronous request to load the start value 9 |
| cnt_en | input | 1 | Count enable |
| count | output | 8 | Current count value |
| at_end | output | 1 | High while the count equals 69 |

## Verification
A wrong slice state or a broken carry link shows at `count` on the very next edge. Examples are a missing increment at a nibble boundary, a high nibble that steps without a carry, and a load that fires at the wrong value. A terminal comparator that misfires shows up at once on `at_end`, and one edge later as a jump to 9 that comes too early or never comes. Because every value in the cycle is compared on every clock, no faulty state can persist for more than one cycle without being seen.

// File: rtl/range_ctr_pkg.sv
package range_ctr_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_STEP = 2'd1,
    ACT_LOAD = 2'd2
  } slice_act_e;

  // Load beats counting; counting beats holding.
  function automatic slice_act_e pick_act(input logic load, input logic en);
    if (load)    return ACT_LOAD;
    else if (en) return ACT_STEP;
    else         return ACT_HOLD;
  endfunction

  // Combined load request: explicit initialise or enabled arrival at the end value.
  function automatic logic want_load(input logic init, input logic hit, input logic en);
    return init | (hit & en);
  endfunction

endpackage

// File: rtl/nib_slice.sv
module nib_slice
  import range_ctr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         co
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  slice_act_e act;

  always_comb act = pick_act(load, en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      unique case (act)
        ACT_LOAD: q <= d;
        ACT_STEP: q <= q + W'(1);
        default:  q <= q;
      endcase
    end
  end

  // Carry out: slice is full and counting.
  always_comb co = en && (q == ALL_ONES);

endmodule

// File: rtl/term_detect.sv
module term_detect #(
  parameter int CW   = 8,
  parameter int STOP = 69
) (
  input  logic [CW-1:0] value,
  output logic          hit
);

  localparam logic [CW-1:0] STOP_V = CW'(STOP);

  always_comb hit = (value == STOP_V);

endmodule

// File: rtl/range_ctr.sv
module range_ctr
  import range_ctr_pkg::*;
#(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 2,
  parameter int START    = 9,
  parameter int STOP     = 69
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        init,
  input  logic                        cnt_en,
  output logic [SLICE_W*N_SLICES-1:0] count,
  output logic                        at_end
);

  localparam int CW = SLICE_W * N_SLICES;
  localparam logic [CW-1:0] START_V = CW'(START);

  logic [CW-1:0]     count_q;
  logic [N_SLICES:0] chain;
  logic              hit_w;
  logic              load_w;
  logic              low_carry;

  always_comb chain[0] = cnt_en;

  for (genvar gi = 0; gi < N_SLICES; gi++) begin : g_slice
    nib_slice #(.W(SLICE_W)) u_slice (
      .clk  (clk),
      .rst_n(rst_n),
      .load (load_w),
      .en   (chain[gi]),
      .d    (START_V[gi*SLICE_W +: SLICE_W]),
      .q    (count_q[gi*SLICE_W +: SLICE_W]),
      .co   (chain[gi+1])
    );
  end

  term_detect #(.CW(CW), .STOP(STOP)) u_term (
    .value(count_q),
    .hit  (hit_w)
  );

  always_comb begin
    load_w    = want_load(init, hit_w, cnt_en);
    low_carry = chain[1];
    count     = count_q;
    at_end    = hit_w;
  end

endmodule

// File: rtl/range_ctr_chk.sv
module range_ctr_chk #(
  parameter int SLICE_W = 4,
  parameter int CW      = 8,
  parameter int START   = 9,
  parameter int STOP    = 69
) (
  input logic          clk,
  input logic          rst_n,
  input logic          init,
  input logic          cnt_en,
  input logic [CW-1:0] count,
  input logic          at_end,
  input logic          load_w,
  input logic          low_carry
);

  localparam logic [CW-1:0]      START_V = CW'(START);
  localparam logic [CW-1:0]      STOP_V  = CW'(STOP);
  localparam logic [SLICE_W-1:0] ZERO_N  = '0;

  // R2
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !init && !at_end) |=> (count == CW'($past(count) + 1)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !init) |=> $stable(count));

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && at_end && !init) |=> (count == START_V));

  // R5
  init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (count == START_V));

  // R6
  flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |-> (count == STOP_V));

  // R7
  carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (low_carry && !load_w) |=>
      (count[SLICE_W-1:0] == ZERO_N) &&
      (count[CW-1:SLICE_W] == (CW-SLICE_W)'($past(count[CW-1:SLICE_W]) + 1)));

  // R4
  in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= STOP_V);

endmodule

bind range_ctr range_ctr_chk #(
  .SLICE_W(SLICE_W),
  .CW     (SLICE_W*N_SLICES),
  .START  (START),
  .STOP   (STOP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .init     (init),
  .cnt_en   (cnt_en),
  .count    (count),
  .at_end   (at_end),
  .load_w   (load_w),
  .low_carry(low_carry)
);

// File: tb/tb_range_ctr.sv
module tb_range_ctr;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init = 1'b0;
  logic       cnt_en = 1'b0;
  logic [7:0] count;
  logic       at_end;

  int total = 0;
  int bad = 0;
  int exp_v = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  range_ctr dut (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (init),
    .cnt_en(cnt_en),
    .count (count),
    .at_end(at_end)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // Drive at negedge, let one edge pass, check at following negedge.
  task automatic step(input logic i, input logic e);
    string tag;
    init   = i;
    cnt_en = e;
    if (i)                    tag = "R5";
    else if (!e)              tag = "R3";
    else if (exp_v == 69)     tag = "R4";
    else if (exp_v % 16 == 15) tag = "R7";
    else                      tag = "R2";
    @(posedge clk);
    if (i)        exp_v = 9;
    else if (e)   exp_v = (exp_v == 69) ? 9 : exp_v + 1;
    @(negedge clk);
    check(tag, int'(count), exp_v);
    check("R6", int'(at_end), (exp_v == 69) ? 1 : 0);
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    @(negedge clk);
    check("R1", int'(count), 0);
    check("R1", int'(at_end), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(count), 0);
    exp_v = 0;

    // Climb from zero, then three complete wraps.
    for (int k = 0; k < 70 + 61 * 3; k++) step(1'b0, 1'b1);

    // Hold at the end value.
    while (exp_v != 69) step(1'b0, 1'b1);
    for (int k = 0; k < 4; k++) step(1'b0, 1'b0);
    step(1'b0, 1'b1);

    // Initialise mid-sequence, with and without enable, and at the end value.
    for (int k = 0; k < 20; k++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    for (int k = 0; k < 30; k++) step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    while (exp_v != 69) step(1'b0, 1'b1);
    step(1'b1, 1'b1);

    // Enable toggled in pseudo-random stretches, occasional initialise.
    for (int k = 0; k < 600; k++) begin
      lfsr = lfsr_next(lfsr);
      step(lfsr[7:0] == 8'h5A, lfsr[3] | lfsr[1]);
    end

    // Asynchronous reset mid-run, then climb from zero again.
    for (int k = 0; k < 5; k++) step(1'b0, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R1", int'(count), 0);
    check("R1", int'(at_end), 0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_v = 0;
    for (int k = 0; k < 140; k++) step(1'b0, 1'b1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule